// File: doc/BRIEF.md
# Ethernet PHY Bring-Up Sequencer

This block takes an attached Ethernet PHY through a soft reset and then identifies it, with no software involvement. It talks to the PHY's management registers only through a request/acknowledge port. An external management master serialises each request on the wire and reports the read data, or a read error, together with a single-cycle acknowledge. A pulse on `start` launches the sequence.

The sequencer first sets the PHY's reset bit with a read-modify-write of the control register. It waits a settle interval and then polls until the reset bit drops. A poll budget and a fixed gap between polls bound this wait. If the PHY comes out of reset still isolated, the sequencer clears the isolate bit. It then reads the 32-bit identifier and decides whether the part matches one known vendor device or falls back to a generic profile. It builds a capability vector from the basic status register, and from the extended status register when that register is present. For the vendor device only, it programs the interface-mode field of a vendor register. The final result is held on `done` or `fail`, together with the profile flag, the identifier and the capabilities.

All time intervals are counted in microseconds. A divider of `CLK_PER_US` clock cycles derives the microsecond from the system clock.

Top module: `phy_bringup_seq`

## Requirements
- R1: The sequence reads register 0 and writes it back with bit 15 (reset) set, bit 10 (isolate) cleared and every other bit unchanged. A read error on that first read ends in fail.
- R2: The first poll request is presented on the clock edge that comes SETTLE_US*CLK_PER_US+1 edges after the edge that accepts the reset write's acknowledge.
- R3: Each poll reads register 0. Reset has finished when bit 15 reads 0 and the error flag is low. A poll that returns an error, or a poll with bit 15 set, leads to another poll, issued GAP_US*CLK_PER_US+1 edges after the edge that accepted the previous poll's acknowledge.
- R4: If POLL_LIMIT polls all fail to see reset finished, the sequencer enters fail, issues no further requests and reads no identifier.
- R5: If bit 10 reads as 1 in the successful poll, register 0 is written once more with bit 10 cleared and the other bits as read. Otherwise register 0 is written only once.
- R6: The identifier is register 2 in bits 31:16 and register 3 in bits 15:0. The vendor profile is selected exactly when (id & 0x000FFFF0) == 0x000FC410; any other value gives the generic profile.
- R7: For the vendor profile only, register 23 is read and written back with bits 13:12 set from `if_mode`. The codes are 0 to 00 (GMII), 1 to 01 (RGMII), 2 to 10 (TBI) and 3 to 11 (RTBI); codes 4 to 7 also give 01. Other bits are kept. In the generic profile, register 23 is never accessed.
- R8: The capabilities are built from register 1 and encoded as follows: bit 0 is autoneg-capable (status bit 3), bits 1 and 2 are 10 half/full (status bits 11 and 12), and bits 3 and 4 are 100 half/full (status bits 13 and 14). Bits 5 and 6 are 1000 half/full, taken from register 15 bits 12 and 13. Register 15 is read only when status bit 8 is set; otherwise bits 5 and 6 are 0. Bit 7 (MII) is always 1.
- R9: A read error on the identifier, status, extended-status or interface-mode read ends the sequence in fail, and no later request is issued.
- R10: A request holds its valid, direction, register and write data steady until it is acknowledged.
- R11: After reset, `busy`, `done`, `fail` and `mdio_req_valid` are low. `done` and `fail` hold until the next `start`. A `start` after either outcome runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches the sequence when not busy |
| if_mode | input | 3 | Interface mode for the vendor device, sampled at start |
| mdio_req_valid | output | 1 | Management request pending |
| mdio_req_write | output | 1 | 1 for a register write, 0 for a read |
| mdio_req_reg | output | 5 | Register address |
| mdio_req_wdata | output | 16 | Write data |
| mdio_ack | input | 1 | One-cycle completion of the pending request |
| mdio_ack_err | input | 1 | Read failed, valid with the acknowledge |
| mdio_rdata | input | 16 | Read data, valid with the acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished successfully |
| fail | output | 1 | No usable device found |
| vendor_profile | output | 1 | Vendor device matched |
| phy_id | output | 32 | Identifier read from registers 2 and 3 |
| caps | output | 8 | Capability vector |

## Verification
The assertions assume that the management master raises `mdio_ack` for one cycle, and only while a request is pending. They also assume that read data and the error flag are valid only in that cycle. The bench's register model meets this: it notices a request at a falling edge, waits a fixed latency, and then drives the acknowledge, data and error for exactly one clock. The assertions on the settle and gap windows assume that `start` does not land while the block is busy. The bench pulses `start` only when the block is idle and waits for `done` or `fail` before the next scenario.

// File: rtl/phy_bringup_pkg.sv
package phy_bringup_pkg;

  localparam logic [4:0] REG_CTL    = 5'd0;
  localparam logic [4:0] REG_STAT   = 5'd1;
  localparam logic [4:0] REG_IDH    = 5'd2;
  localparam logic [4:0] REG_IDL    = 5'd3;
  localparam logic [4:0] REG_XSTAT  = 5'd15;
  localparam logic [4:0] REG_IFMODE = 5'd23;

  localparam int CTL_RST_BIT  = 15;
  localparam int CTL_ISO_BIT  = 10;
  localparam int STAT_XST_BIT = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTL, S_WR_CTL, S_SETTLE, S_POLL, S_GAP, S_UNISO,
    S_RD_IDH, S_RD_IDL, S_RD_STAT, S_RD_XST, S_RD_IFM, S_WR_IFM,
    S_DONE, S_FAIL
  } seq_state_t;

  // control word that starts a soft reset and leaves isolation
  function automatic logic [15:0] reset_word(input logic [15:0] c);
    logic [15:0] r;
    r = c;
    r[CTL_RST_BIT] = 1'b1;
    r[CTL_ISO_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [15:0] uniso_word(input logic [15:0] c);
    logic [15:0] r;
    r = c;
    r[CTL_ISO_BIT] = 1'b0;
    return r;
  endfunction

  function automatic logic [1:0] ifmode_code(input logic [2:0] m);
    case (m)
      3'd0:    return 2'b00;
      3'd2:    return 2'b10;
      3'd3:    return 2'b11;
      default: return 2'b01;
    endcase
  endfunction

  function automatic logic [15:0] ifmode_word(input logic [15:0] w, input logic [2:0] m);
    return {w[15:14], ifmode_code(m), w[11:0]};
  endfunction

  // capability vector: [0] AN, [1] 10H, [2] 10F, [3] 100H, [4] 100F,
  // [5] 1000H, [6] 1000F, [7] MII
  function automatic logic [7:0] caps_from(input logic [15:0] st,
                                           input logic [15:0] xs,
                                           input logic        xs_ok);
    logic [7:0] c;
    c    = '0;
    c[0] = st[3];
    c[1] = st[11];
    c[2] = st[12];
    c[3] = st[13];
    c[4] = st[14];
    c[5] = xs_ok & xs[12];
    c[6] = xs_ok & xs[13];
    c[7] = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/us_tick_gen.sv
module us_tick_gen #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (restart || tick)  div_q <= '0;
    else                       div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
  parameter int CLK_PER_US = 125,
  parameter int US_W       = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [US_W-1:0] load_us,
  output logic            expired
);
  logic            tick;
  logic [US_W-1:0] left_q;

  us_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      left_q <= '0;
    else if (load)                   left_q <= load_us;
    else if (tick && left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign expired = (left_q == '0);

  // the remaining time only moves down between loads
  assert_timer_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && left_q != '0) |=> (left_q <= $past(left_q)));
endmodule

// File: rtl/profile_match.sv
module profile_match #(
  parameter logic [31:0] ID_MASK  = 32'h000F_FFF0,
  parameter logic [31:0] ID_MATCH = 32'h000F_C410
) (
  input  logic [31:0] id,
  output logic        hit
);
  assign hit = ((id & ID_MASK) == ID_MATCH);
endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq
  import phy_bringup_pkg::*;
#(
  parameter int          CLK_PER_US = 125,
  parameter int          SETTLE_US  = 300,
  parameter int          GAP_US     = 10,
  parameter int          POLL_LIMIT = 10000,
  parameter logic [31:0] ID_MASK    = 32'h000F_FFF0,
  parameter logic [31:0] ID_MATCH   = 32'h000F_C410
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  if_mode,
  output logic        mdio_req_valid,
  output logic        mdio_req_write,
  output logic [4:0]  mdio_req_reg,
  output logic [15:0] mdio_req_wdata,
  input  logic        mdio_ack,
  input  logic        mdio_ack_err,
  input  logic [15:0] mdio_rdata,
  output logic        busy,
  output logic        done,
  output logic        fail,
  output logic        vendor_profile,
  output logic [31:0] phy_id,
  output logic [7:0]  caps
);
  localparam int MAX_US = (SETTLE_US > GAP_US) ? SETTLE_US : GAP_US;
  localparam int US_W   = $clog2(MAX_US + 1);
  localparam int PW     = $clog2(POLL_LIMIT + 1);

  seq_state_t      state, nxt;
  logic [15:0]     ctl_q, stat_q, ifm_q;
  logic [31:0]     id_q;
  logic [2:0]      mode_q;
  logic [PW-1:0]   poll_cnt;
  logic            vendor_q;
  logic [7:0]      caps_q;

  // named internal events
  logic            idle_like, launch, acc, rd_ok, rd_bad, last_poll;
  logic            tm_load, tm_expired, id_hit;
  logic [US_W-1:0] tm_len;

  assign idle_like = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);
  assign launch    = idle_like && start;
  assign acc       = mdio_req_valid && mdio_ack;
  assign rd_ok     = acc && !mdio_ack_err;
  assign rd_bad    = acc && mdio_ack_err;
  assign last_poll = (poll_cnt == PW'(POLL_LIMIT - 1));

  wait_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tm_load),
    .load_us (tm_len),
    .expired (tm_expired)
  );

  profile_match #(.ID_MASK(ID_MASK), .ID_MATCH(ID_MATCH)) u_match (
    .id  ({id_q[31:16], mdio_rdata}),
    .hit (id_hit)
  );

  // request decode
  always_comb begin
    mdio_req_valid = 1'b1;
    mdio_req_write = 1'b0;
    mdio_req_reg   = REG_CTL;
    mdio_req_wdata = '0;
    case (state)
      S_RD_CTL, S_POLL: mdio_req_reg = REG_CTL;
      S_WR_CTL: begin mdio_req_write = 1'b1; mdio_req_wdata = reset_word(ctl_q); end
      S_UNISO:  begin mdio_req_write = 1'b1; mdio_req_wdata = uniso_word(ctl_q); end
      S_RD_IDH:  mdio_req_reg = REG_IDH;
      S_RD_IDL:  mdio_req_reg = REG_IDL;
      S_RD_STAT: mdio_req_reg = REG_STAT;
      S_RD_XST:  mdio_req_reg = REG_XSTAT;
      S_RD_IFM:  mdio_req_reg = REG_IFMODE;
      S_WR_IFM: begin
        mdio_req_reg   = REG_IFMODE;
        mdio_req_write = 1'b1;
        mdio_req_wdata = ifmode_word(ifm_q, mode_q);
      end
      default: mdio_req_valid = 1'b0;
    endcase
  end

  // sequencing
  always_comb begin
    nxt     = state;
    tm_load = 1'b0;
    tm_len  = US_W'(SETTLE_US);
    case (state)
      S_IDLE, S_DONE, S_FAIL: if (start) nxt = S_RD_CTL;
      S_RD_CTL: if (rd_bad) nxt = S_FAIL; else if (rd_ok) nxt = S_WR_CTL;
      S_WR_CTL: if (acc) begin nxt = S_SETTLE; tm_load = 1'b1; end
      S_SETTLE: if (tm_expired) nxt = S_POLL;
      S_POLL: begin
        if (rd_ok && !mdio_rdata[CTL_RST_BIT])
          nxt = mdio_rdata[CTL_ISO_BIT] ? S_UNISO : S_RD_IDH;
        else if (acc) begin
          if (last_poll) nxt = S_FAIL;
          else begin
            nxt     = S_GAP;
            tm_load = 1'b1;
            tm_len  = US_W'(GAP_US);
          end
        end
      end
      S_GAP:    if (tm_expired) nxt = S_POLL;
      S_UNISO:  if (acc) nxt = S_RD_IDH;
      S_RD_IDH: if (rd_bad) nxt = S_FAIL; else if (rd_ok) nxt = S_RD_IDL;
      S_RD_IDL: if (rd_bad) nxt = S_FAIL; else if (rd_ok) nxt = S_RD_STAT;
      S_RD_STAT: begin
        if (rd_bad) nxt = S_FAIL;
        else if (rd_ok) begin
          if (mdio_rdata[STAT_XST_BIT]) nxt = S_RD_XST;
          else                          nxt = vendor_q ? S_RD_IFM : S_DONE;
        end
      end
      S_RD_XST: if (rd_bad) nxt = S_FAIL; else if (rd_ok) nxt = vendor_q ? S_RD_IFM : S_DONE;
      S_RD_IFM: if (rd_bad) nxt = S_FAIL; else if (rd_ok) nxt = S_WR_IFM;
      S_WR_IFM: if (acc) nxt = S_DONE;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ctl_q    <= '0;
      stat_q   <= '0;
      ifm_q    <= '0;
      id_q     <= '0;
      mode_q   <= '0;
      poll_cnt <= '0;
      vendor_q <= 1'b0;
      caps_q   <= '0;
    end else begin
      state <= nxt;
      if (launch) begin
        poll_cnt <= '0;
        vendor_q <= 1'b0;
        caps_q   <= '0;
        id_q     <= '0;
        mode_q   <= if_mode;
      end
      if (state == S_RD_CTL && rd_ok) ctl_q <= mdio_rdata;
      if (state == S_POLL && rd_ok && !mdio_rdata[CTL_RST_BIT]) ctl_q <= mdio_rdata;
      if (state == S_POLL && nxt == S_GAP) poll_cnt <= poll_cnt + 1'b1;
      if (state == S_RD_IDH && rd_ok) id_q[31:16] <= mdio_rdata;
      if (state == S_RD_IDL && rd_ok) begin
        id_q[15:0] <= mdio_rdata;
        vendor_q   <= id_hit;
      end
      if (state == S_RD_STAT && rd_ok) begin
        stat_q <= mdio_rdata;
        caps_q <= caps_from(mdio_rdata, 16'h0000, 1'b0);
      end
      if (state == S_RD_XST && rd_ok) caps_q <= caps_from(stat_q, mdio_rdata, 1'b1);
      if (state == S_RD_IFM && rd_ok) ifm_q <= mdio_rdata;
    end
  end

  assign busy           = !idle_like;
  assign done           = (state == S_DONE);
  assign fail           = (state == S_FAIL);
  assign vendor_profile = vendor_q;
  assign phy_id         = id_q;
  assign caps           = caps_q;

  // ---------------- assertions ----------------
  logic [31:0]   wait_cyc;
  logic [PW:0]   polls_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wait_cyc <= '0;
    else if (state == S_SETTLE || state == S_GAP) wait_cyc <= wait_cyc + 1'b1;
    else wait_cyc <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) polls_seen <= '0;
    else if (launch) polls_seen <= '0;
    else if (state == S_POLL && acc) polls_seen <= polls_seen + 1'b1;
  end

  assert_reset_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req_valid && mdio_req_write && state == S_WR_CTL) |->
      (mdio_req_wdata[CTL_RST_BIT] && !mdio_req_wdata[CTL_ISO_BIT]));

  assert_settle_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SETTLE && tm_expired) |-> (wait_cyc == 32'(SETTLE_US * CLK_PER_US)));

  assert_gap_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAP && tm_expired) |-> (wait_cyc == 32'(GAP_US * CLK_PER_US)));

  assert_poll_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FAIL && $past(state) == S_POLL) |-> (polls_seen == (PW+1)'(POLL_LIMIT)));

  assert_ifmode_vendor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD_IFM || state == S_WR_IFM) |-> vendor_q);

  assert_xstat_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD_XST) |-> stat_q[STAT_XST_BIT]);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req_valid && !mdio_ack) |=>
      (mdio_req_valid && $stable(mdio_req_reg) && $stable(mdio_req_write) &&
       $stable(mdio_req_wdata)));

  assert_done_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
endmodule

// File: tb/phy_bringup_seq_tb.sv
`timescale 1ns/1ps
module phy_bringup_seq_tb;
  localparam int CPU  = 4;
  localparam int SETU = 300;
  localparam int GAPU = 10;
  localparam int PLIM = 6;
  localparam int LAT  = 2;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0]  if_mode = 3'd1;
  logic        req_valid, req_write;
  logic [4:0]  req_reg;
  logic [15:0] req_wdata;
  logic        ack = 1'b0, ack_err = 1'b0;
  logic [15:0] rdata = '0;
  logic        busy, done, fail, vendor;
  logic [31:0] phy_id;
  logic [7:0]  caps;

  int checks = 0, errors = 0, cyc = 0;

  // register model of the PHY
  logic [15:0] regs [32];
  int rd_cnt [32];
  int wr_cnt [32];
  int reset_left = 0, cfg_reset_polls = 0, err_reg = -1, err_nth = 0;
  bit cfg_iso_stick = 1'b0;
  int t_rst_ack = 0, t_poll1_req = 0, t_poll1_ack = 0, t_poll2_req = 0;
  logic [15:0] first_wr0 = '0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  phy_bringup_seq #(.CLK_PER_US(CPU), .SETTLE_US(SETU), .GAP_US(GAPU), .POLL_LIMIT(PLIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .if_mode(if_mode),
    .mdio_req_valid(req_valid), .mdio_req_write(req_write), .mdio_req_reg(req_reg),
    .mdio_req_wdata(req_wdata), .mdio_ack(ack), .mdio_ack_err(ack_err), .mdio_rdata(rdata),
    .busy(busy), .done(done), .fail(fail), .vendor_profile(vendor), .phy_id(phy_id), .caps(caps)
  );

  always begin : phy_model
    int r;
    logic [15:0] v;
    @(negedge clk);
    if (req_valid) begin
      r = int'(req_reg);
      if (!req_write && r == 0 && rd_cnt[0] == 1) t_poll1_req = cyc;
      if (!req_write && r == 0 && rd_cnt[0] == 2) t_poll2_req = cyc;
      repeat (LAT) @(negedge clk);
      if (req_write) begin
        wr_cnt[r] = wr_cnt[r] + 1;
        if (r == 0 && req_wdata[15]) begin
          if (wr_cnt[0] == 1) begin first_wr0 = req_wdata; t_rst_ack = cyc; end
          reset_left = cfg_reset_polls;
          v = req_wdata & 16'h7FFF;
          if (cfg_iso_stick) v[10] = 1'b1;
          regs[0] = v;
        end else regs[r] = req_wdata;
        rdata = '0;
        ack_err = 1'b0;
      end else begin
        rd_cnt[r] = rd_cnt[r] + 1;
        v = regs[r];
        if (r == 0 && reset_left > 0) begin v[15] = 1'b1; reset_left = reset_left - 1; end
        if (r == 0 && rd_cnt[0] == 2) t_poll1_ack = cyc;
        rdata = v;
        ack_err = (r == err_reg) && (rd_cnt[r] == err_nth);
      end
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      ack_err = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_caps(input logic [15:0] s, input logic [15:0] x);
    logic e;
    e = s[8];
    return {1'b1, e & x[13], e & x[12], s[14], s[13], s[12], s[11], s[3]};
  endfunction

  task automatic setup(input logic [15:0] ctl, input logic [15:0] idh, input logic [15:0] idl,
                       input logic [15:0] st, input logic [15:0] xs, input logic [15:0] ifm,
                       input int rpolls, input bit iso, input int ereg, input int enth);
    for (int i = 0; i < 32; i++) begin regs[i] = '0; rd_cnt[i] = 0; wr_cnt[i] = 0; end
    regs[0] = ctl; regs[2] = idh; regs[3] = idl; regs[1] = st; regs[15] = xs; regs[23] = ifm;
    cfg_reset_polls = rpolls; reset_left = 0; cfg_iso_stick = iso;
    err_reg = ereg; err_nth = enth;
  endtask

  task automatic run_seq;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done || fail) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state;
    chk("R11 busy after reset", busy, 0);
    chk("R11 done after reset", done, 0);
    chk("R11 fail after reset", fail, 0);
    chk("R11 no request after reset", req_valid, 0);
  endtask

  task automatic t_generic;
    if_mode = 3'd1;
    setup(16'h3100, 16'h0141, 16'h0C20, 16'h7909, 16'h3000, 16'h5A5A, 2, 0, -1, 0);
    run_seq();
    chk("R3 done", done, 1);
    chk("R1 reset write word", first_wr0, 16'hB100);
    chk("R2 settle window", t_poll1_req - t_rst_ack, SETU * CPU + 2);
    chk("R3 poll gap", t_poll2_req - t_poll1_ack, GAPU * CPU + 2);
    chk("R3 poll count", rd_cnt[0], 4);
    chk("R5 single ctl write", wr_cnt[0], 1);
    chk("R6 id", phy_id, 32'h0141_0C20);
    chk("R6 generic profile", vendor, 0);
    chk("R7 reg23 untouched", rd_cnt[23] + wr_cnt[23], 0);
    chk("R8 caps with ext", caps, exp_caps(16'h7909, 16'h3000));
    chk("R8 ext read once", rd_cnt[15], 1);
    repeat (10) @(negedge clk);
    chk("R11 done holds", done, 1);
  endtask

  task automatic t_vendor_iso;
    if_mode = 3'd2;
    setup(16'h1540, 16'h000F, 16'hC417, 16'h7809, 16'h3000, 16'h5A5A, 1, 1, -1, 0);
    run_seq();
    chk("R6 vendor done", done, 1);
    chk("R6 vendor profile", vendor, 1);
    chk("R6 vendor id", phy_id, 32'h000F_C417);
    chk("R1 reset word keeps bits", first_wr0, 16'h9140);
    chk("R5 isolate cleanup writes", wr_cnt[0], 2);
    chk("R5 isolate cleared", regs[0], 16'h1140);
    chk("R7 TBI code", regs[23], 16'h6A5A);
    chk("R8 no ext read", rd_cnt[15], 0);
    chk("R8 caps without ext", caps, 8'h9F);
  endtask

  task automatic t_vendor_mode(input logic [2:0] m, input logic [15:0] init, input logic [15:0] exp);
    if_mode = m;
    setup(16'h0000, 16'h000F, 16'hC41A, 16'h0009, 16'h0000, init, 0, 0, -1, 0);
    run_seq();
    chk("R7 mode done", done, 1);
    chk("R7 mode field", regs[23], exp);
  endtask

  task automatic t_near_miss;
    setup(16'h0000, 16'h000F, 16'hC400, 16'h0009, 16'h0000, 16'h1234, 0, 0, -1, 0);
    run_seq();
    chk("R6 near miss generic", vendor, 0);
    chk("R7 near miss reg23 untouched", regs[23], 16'h1234);
    setup(16'h0000, 16'h100F, 16'hC41F, 16'h0009, 16'h0000, 16'h1234, 0, 0, -1, 0);
    if_mode = 3'd1;
    run_seq();
    chk("R6 masked high bits match", vendor, 1);
  endtask

  task automatic t_timeout;
    setup(16'h0000, 16'h0141, 16'h0C20, 16'h0009, 16'h0000, 16'h0000, 1000, 0, -1, 0);
    run_seq();
    chk("R4 fail", fail, 1);
    chk("R4 not done", done, 0);
    chk("R4 poll budget", rd_cnt[0], 1 + PLIM);
    chk("R4 no id read", rd_cnt[2], 0);
    repeat (20) @(negedge clk);
    chk("R4 quiet after fail", req_valid, 0);
    chk("R11 fail holds", fail, 1);
  endtask

  task automatic t_read_err(input int reg_no, input string tag);
    setup(16'h0000, 16'h0141, 16'h0C20, 16'h0109, 16'h3000, 16'h0000, 0, 0, reg_no, 1);
    run_seq();
    chk(tag, fail, 1);
    repeat (10) @(negedge clk);
    chk({tag, " quiet"}, req_valid, 0);
  endtask

  task automatic t_poll_err;
    setup(16'h0000, 16'h0141, 16'h0C20, 16'h0009, 16'h0000, 16'h0000, 0, 0, 0, 2);
    run_seq();
    chk("R3 errored poll repeated", rd_cnt[0], 3);
    chk("R3 done after errored poll", done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset_state();
    t_generic();
    t_vendor_iso();
    t_vendor_mode(3'd5, 16'h0F0F, 16'h1F0F);
    t_vendor_mode(3'd3, 16'hCFFF, 16'hFFFF);
    t_vendor_mode(3'd0, 16'hFFFF, 16'hCFFF);
    t_near_miss();
    t_timeout();
    t_read_err(0, "R1 ctl read error fails");
    t_read_err(2, "R9 id read error fails");
    t_read_err(1, "R9 status read error fails");
    t_read_err(15, "R9 ext read error fails");
    t_poll_err();
    t_generic();
    chk("R11 restart after fail", done, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule